// File: doc/BRIEF.md
# Byte-stream debug channel data register

This block is a scan data register that a debug host reaches through a test access port once the debug instruction is loaded. It turns the bit-serial Shift-DR traffic into a byte channel in both directions. Incoming bits, least significant first, are gathered into bytes. Each byte goes to the on-chip debug engine on a valid/ready port in the same clock that its eighth bit is shifted in. No Update-DR pulse is needed.

Outgoing response bytes come from the engine on a transmit port and are serialised onto TDO. Two byte values are reserved: the pad value 0xAA and the escape marker 0x55. Whenever the engine has nothing to send, the register outputs the pad value. A response byte equal to either reserved value is sent as the marker followed by the byte XOR 0x55. Commands and responses use separate scans. Every Capture-DR returns both directions to a byte boundary, so a corrupted stream recovers on the next scan. Response scans start with one filler bit, which the host discards.

Top module: `dbg_byte_dr`

## Requirements
- R1: Received bits are taken LSB first. After the eighth selected shift clock since capture, `rx_valid` is high and `rx_data` holds those eight bits.
- R2: `update` has no effect. A pulse of it between shift clocks neither delivers a byte nor moves the byte boundary.
- R3: Capture-DR with the instruction selected discards a partly received byte, and the next eight shift clocks form a full byte.
- R4: While `sel` is low, capture and shift have no effect on either direction.
- R5: After a selected capture, the first TDO bit is a filler 0. The response byte follows in the next eight shift clocks, LSB first.
- R6: When the engine offers no byte, TDO carries the pad byte 0xAA.
- R7: A response byte of 0xAA or 0x55 is sent as 0x55 followed by the byte XOR 0x55. A marker and its escaped byte use one `tx_ready` pulse.
- R8: All other response bytes are sent unchanged, and incoming bytes are never unstuffed (0x55 arrives as 0x55).
- R9: If a scan ends after the marker has started, the escaped byte is the first byte of the next scan.
- R10: A response byte that has been loaded but has had no bit shifted out stays in place across a capture. The engine hands over each byte exactly once.
- R11: `rx_valid` stays high until `rx_ready` is seen. A newly completed byte replaces an unacknowledged one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Debug instruction is loaded in the IR |
| capture | input | 1 | TAP in Capture-DR |
| shift | input | 1 | TAP in Shift-DR |
| update | input | 1 | TAP in Update-DR (not used for data) |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| rx_data | output | 8 | Received command byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Engine accepts the received byte |
| tx_data | input | 8 | Response byte from engine |
| tx_valid | input | 1 | Engine offers a response byte |
| tx_ready | output | 1 | Response byte taken this clock |

## Verification
`rx_valid` and `rx_data` settle at the rising edge that shifts the eighth bit, so the bench reads them at the falling edge that follows. `tdo` comes only from registers. Each bit is read at the falling edge just before the rising edge that shifts it, so the bit read in slot k is the bit the host sees in that slot. The capture edge sets up the filler bit in slot 0. The bench engine pops a byte from its queue one half clock after an edge at which `tx_ready` was high. Response contents are therefore checked only after the whole scan has been read back and the queue state has settled.

// File: rtl/dbg_byte_dr.sv
module dbg_byte_dr #(
  parameter int W = 8,
  parameter logic [W-1:0] PAD = 8'hAA,
  parameter logic [W-1:0] ESC = 8'h55
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         sel,
  input  logic         capture,
  input  logic         shift,
  input  logic         update,
  input  logic         tdi,
  output logic         tdo,
  output logic [W-1:0] rx_data,
  output logic         rx_valid,
  input  logic         rx_ready,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  rx_sr, tx_sr, esc_val, nb;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic          lead, fresh, is_pad, esc_pend, npad, stuff;
  logic          sh, cap, rx_last, tx_edge, load;

  assign sh      = sel & shift;
  assign cap     = sel & capture;
  assign rx_last = sh && (rx_cnt == LAST);
  assign tx_edge = sh && !lead && (tx_cnt == LAST);
  assign load    = (cap && !(fresh && !is_pad)) || tx_edge;
  assign stuff   = (tx_data == PAD) || (tx_data == ESC);
  assign tx_ready = load && !esc_pend && tx_valid;
  assign tdo     = lead ? 1'b0 : tx_sr[0];

  always_comb begin
    npad = 1'b0;
    if (esc_pend)      nb = esc_val ^ ESC;
    else if (tx_valid) nb = stuff ? ESC : tx_data;
    else begin
      nb   = PAD;
      npad = 1'b1;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      rx_sr    <= '0;
      rx_cnt   <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (cap) rx_cnt <= '0;
      else if (sh) begin
        rx_sr  <= {tdi, rx_sr[W-1:1]};
        rx_cnt <= rx_last ? '0 : rx_cnt + 1'b1;
      end
      if (rx_last) begin
        rx_data  <= {tdi, rx_sr[W-1:1]};
        rx_valid <= 1'b1;
      end else if (rx_valid && rx_ready) rx_valid <= 1'b0;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tx_sr    <= PAD;
      tx_cnt   <= '0;
      lead     <= 1'b0;
      fresh    <= 1'b1;
      is_pad   <= 1'b1;
      esc_pend <= 1'b0;
      esc_val  <= '0;
    end else begin
      if (cap) begin
        lead   <= 1'b1;
        tx_cnt <= '0;
      end else if (sh) begin
        if (lead) lead <= 1'b0;
        else begin
          tx_cnt <= (tx_cnt == LAST) ? '0 : tx_cnt + 1'b1;
          tx_sr  <= {1'b0, tx_sr[W-1:1]};
          fresh  <= 1'b0;
        end
      end
      if (load) begin
        tx_sr  <= nb;
        fresh  <= 1'b1;
        is_pad <= npad;
        if (esc_pend) esc_pend <= 1'b0;
        else if (tx_valid && stuff) begin
          esc_pend <= 1'b1;
          esc_val  <= tx_data;
        end
      end
    end
  end

  a_r1_rise_needs_shift: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(rx_valid) |-> $past(sel && shift));
  a_r2_update_no_delivery: assert property (@(posedge tck) disable iff (!trst_n)
    (update && !shift) |=> !$rose(rx_valid));
  a_r3_capture_aligns: assert property (@(posedge tck) disable iff (!trst_n)
    (sel && capture) |=> (rx_cnt == '0 && tx_cnt == '0));
  a_r4_unselected_idle: assert property (@(posedge tck) disable iff (!trst_n)
    !sel |=> ($stable(rx_cnt) && $stable(tx_cnt) && !$rose(rx_valid)));
  a_r5_filler_first: assert property (@(posedge tck) disable iff (!trst_n)
    (sel && capture) |=> (tdo == 1'b0));
  a_r7_marker_loaded: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(esc_pend) |-> (tx_sr == ESC));
  a_r10_take_only_offered: assert property (@(posedge tck) disable iff (!trst_n)
    tx_ready |-> tx_valid);
endmodule

// File: tb/sim_dbg_byte_dr.sv
module sim_dbg_byte_dr;
  localparam int CLK = 10;

  logic tck = 1'b0, trst_n = 1'b0, sel = 1'b0, capture = 1'b0, shift = 1'b0;
  logic update = 1'b0, tdi = 1'b0, rx_ready = 1'b0;
  logic tdo, rx_valid, tx_valid, tx_ready, took = 1'b0;
  logic [7:0] rx_data, tx_data;
  logic [7:0] ring [16];
  int rd = 0, wr = 0, total = 0, bad = 0;
  logic [63:0] d;

  always #(CLK/2) tck = ~tck;

  dbg_byte_dr u0 (.tck(tck), .trst_n(trst_n), .sel(sel), .capture(capture),
    .shift(shift), .update(update), .tdi(tdi), .tdo(tdo), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready));

  assign tx_valid = (rd != wr);
  assign tx_data  = ring[rd[3:0]];
  always @(posedge tck) took <= tx_ready && tx_valid;
  always @(negedge tck) if (took) rd <= rd + 1;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b);
    ring[wr[3:0]] = b;
    wr = wr + 1;
  endtask

  task automatic cap();
    @(negedge tck); capture = 1'b1;
    @(negedge tck); capture = 1'b0; #1;
  endtask

  task automatic scan(int n, logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge tck); shift = 1'b1; tdi = din[i]; #1 dout[i] = tdo;
    end
    @(negedge tck); shift = 1'b0; #1;
  endtask

  task automatic ack();
    @(negedge tck); rx_ready = 1'b1;
    @(negedge tck); rx_ready = 1'b0; #1;
  endtask

  task automatic t_reset();
    check("R1 reset rx_valid", rx_valid, 0);
    check("R10 reset tx_ready", tx_ready, 0);
  endtask

  task automatic t_rx_byte();
    cap();
    scan(7, 64'h3C, d);
    check("R1 no byte after 7 bits", rx_valid, 0);
    scan(1, 64'h0, d);
    check("R1 valid after 8th bit", rx_valid, 1);
    check("R1 data LSB first", rx_data, 8'h3C);
    repeat (3) @(negedge tck);
    check("R11 held until ready", rx_valid, 1);
    ack();
    check("R11 released by ready", rx_valid, 0);
    cap();
    scan(16, 64'hA555, d);
    check("R8 0x55 taken literally / R11 overwrite", rx_data, 8'hA5);
    ack();
  endtask

  task automatic t_align();
    cap();
    scan(3, 64'h7, d);
    cap();
    scan(8, 64'h81, d);
    check("R3 realigned byte", rx_data, 8'h81);
    check("R3 realigned valid", rx_valid, 1);
    ack();
  endtask

  task automatic t_update();
    cap();
    scan(4, 64'h2, d);
    @(negedge tck); update = 1'b1;
    @(negedge tck); update = 1'b0; #1;
    check("R2 update delivers nothing", rx_valid, 0);
    scan(4, 64'hB, d);
    check("R2 byte boundary kept", rx_data, 8'hB2);
    check("R2 valid after 8 shifts", rx_valid, 1);
    ack();
  endtask

  task automatic t_unsel();
    cap();
    scan(4, 64'h6, d);
    sel = 1'b0;
    cap();
    scan(8, 64'hFF, d);
    check("R4 unselected shift ignored", rx_valid, 0);
    sel = 1'b1;
    scan(4, 64'h9, d);
    check("R4 byte from selected bits only", rx_data, 8'h96);
    ack();
  endtask

  task automatic t_pad();
    cap();
    check("R5 filler bit after capture", tdo, 0);
    scan(17, 64'h0, d);
    check("R5 filler in slot 0", d[0], 0);
    check("R6 pad first byte", d[8:1], 8'hAA);
    check("R6 pad second byte", d[16:9], 8'hAA);
    ack();
  endtask

  task automatic t_plain();
    push(8'h3C);
    cap();
    scan(9, 64'h0, d);
    check("R8 plain byte unchanged", d[8:1], 8'h3C);
    check("R10 byte consumed", rd, wr);
    ack();
  endtask

  task automatic t_stuff();
    push(8'hAA); push(8'h12); push(8'h55);
    cap();
    scan(49, 64'h0, d);
    check("R7 marker for 0xAA", d[8:1], 8'h55);
    check("R7 escaped 0xAA", d[16:9], 8'hFF);
    check("R8 plain between", d[24:17], 8'h12);
    check("R7 marker for 0x55", d[32:25], 8'h55);
    check("R7 escaped 0x55", d[40:33], 8'h00);
    check("R6 pad after data", d[48:41], 8'hAA);
    check("R7 three pops only", rd, wr);
  endtask

  task automatic t_split();
    push(8'hAA);
    cap();
    scan(5, 64'h0, d);
    cap();
    scan(9, 64'h0, d);
    check("R9 escaped byte opens next scan", d[8:1], 8'hFF);
    push(8'h12); push(8'h34);
    cap();
    scan(9, 64'h0, d);
    check("R10 first byte", d[8:1], 8'h12);
    cap();
    scan(9, 64'h0, d);
    check("R10 loaded byte kept over capture", d[8:1], 8'h34);
    check("R10 each byte taken once", rd, wr);
  endtask

  initial begin
    #(CLK * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge tck);
    #1 t_reset();
    trst_n = 1'b1;
    sel = 1'b1;
    t_rx_byte();
    t_align();
    t_update();
    t_unsel();
    t_pad();
    t_plain();
    t_stuff();
    t_split();
    repeat (2) @(negedge tck);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule